// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog counter driven from a slow timebase strobe and controlled through a small register file over a plain write-strobe bus. Software programs a reload value and a prescaler, and refreshes the counter by writing a new value to a refresh register. Arming and disarming need an ordered pair of key words. If the armed counter wraps past all ones, a reset request output is held high for a fixed number of clock cycles and the counter restarts from the reload value.

Every bus write is posted. It is held in a per-register slot and applied only after a fixed number of timebase ticks, which models the hand-off to a slow counter domain. A status word shows which slots still hold a write that has not been applied. Software polls it before it issues the next write to the same register.

Top module: `wdog_timer`

## Requirements
- R1: After reset the counter reads 0, the reload value is 0, the timer is disarmed, no write is pending, the last refresh word is 0 and the reset request output is low.
- R2: Register map (word address on `addr`): 0 revision, 1 control, 2 reload, 3 refresh, 4 key, 5 pending status, 6 counter. Read data is registered and appears one cycle after the address. The revision register reads `{24'b0, REV}`. The key register reads the armed state in bit 0. Unmapped addresses read 0.
- R3: The pending status has bit 0 for control, bit 2 for reload, bit 3 for refresh and bit 4 for key. A write sets its bit. The bit clears, and the write takes effect, on the PEND_TICKS-th timebase tick after the write. A new write to the same register restarts that wait.
- R4: An applied key word 0x0000BBBB followed by an applied 0x00004444 arms the timer.
- R5: An applied key word 0x0000AAAA followed by an applied 0x00005555 disarms the timer.
- R6: Any other word in second place cancels a half-entered key pair. A second-place word that arrives without the matching first word does nothing.
- R7: Control and reload writes that are applied while the timer is armed are discarded.
- R8: While armed, the counter increments once per timebase tick. When control bit 5 is set, it increments once every 2^E ticks instead, where E is control bits 4:2. While disarmed, the counter holds its value.
- R9: An applied refresh word loads the counter from the reload value only if it differs from the previously applied refresh word.
- R10: When the armed counter steps past all ones, the reset request goes high for RST_CYCLES clock cycles, starting the cycle after that step, and the counter loads the reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address, used for writes and reads |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| wdt_rst_o | output | 1 | Reset request pulse |

## Verification
On every cycle, the assertions check four things. A pending flag never clears without a timebase tick. The armed state changes only when a key write is applied. The counter moves only on a tick. Control and reload stay frozen while the timer is armed. A further assertion checks that each reset pulse begins with the counter holding the reload value. The bench's scenarios cover the rest: the ordering of key words and the cancelling of a half-entered pair, the suppression of a repeated refresh word, the prescaled rate, and the exact width of the reset pulse. Each of these behaviours depends on a chain of posted writes rather than on a single cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int A_REV   = 0;
  localparam int A_CTRL  = 1;
  localparam int A_LOAD  = 2;
  localparam int A_TRIG  = 3;
  localparam int A_KEY   = 4;
  localparam int A_STAT  = 5;
  localparam int A_COUNT = 6;

  localparam logic [31:0] KEY_ARM_A    = 32'h0000_BBBB;
  localparam logic [31:0] KEY_ARM_B    = 32'h0000_4444;
  localparam logic [31:0] KEY_DISARM_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_DISARM_B = 32'h0000_5555;

  typedef enum logic [1:0] {KS_IDLE, KS_ARM_HALF, KS_DISARM_HALF} key_state_t;
endpackage

// File: rtl/wdt_post.sv
module wdt_post #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q,
  output logic          pend,
  output logic          fire
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;

  assign fire = tick & pend & (cnt == CW'(1)) & ~wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      cnt  <= '0;
      q    <= '0;
    end else if (wr) begin
      pend <= 1'b1;
      cnt  <= CW'(LAT);
      q    <= din;
    end else if (fire) begin
      pend <= 1'b0;
    end else if (tick && pend) begin
      cnt <= cnt - CW'(1);
    end
  end

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !tick) |=> pend);
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [DW-1:0] word,
  output logic          running
);
  import wdt_pkg::*;
  key_state_t ks;

  always_ff @(posedge clk) begin
    if (rst) begin
      ks      <= KS_IDLE;
      running <= 1'b0;
    end else if (fire) begin
      case (ks)
        KS_ARM_HALF: begin
          if (word == DW'(KEY_ARM_B)) running <= 1'b1;
          ks <= KS_IDLE;
        end
        KS_DISARM_HALF: begin
          if (word == DW'(KEY_DISARM_B)) running <= 1'b0;
          ks <= KS_IDLE;
        end
        default: begin
          if (word == DW'(KEY_ARM_A))         ks <= KS_ARM_HALF;
          else if (word == DW'(KEY_DISARM_A)) ks <= KS_DISARM_HALF;
          else                                ks <= KS_IDLE;
        end
      endcase
    end
  end

  // R4 R5
  run_change_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(running));
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W      = 32,
  parameter int DW         = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             running,
  input  logic             pre_en,
  input  logic [2:0]       pre_exp,
  input  logic [CNT_W-1:0] load_val,
  input  logic             trig_fire,
  input  logic [DW-1:0]    trig_val,
  output logic [CNT_W-1:0] cnt,
  output logic [DW-1:0]    last_trig,
  output logic             rst_o
);
  localparam int PRE_W = 8;
  localparam int RW    = $clog2(RST_CYCLES + 1);

  logic [PRE_W-1:0] pre, lim;
  logic [RW-1:0]    rstc;
  logic             step, reload, ovf;

  assign lim    = pre_en ? ((PRE_W'(1) << pre_exp) - PRE_W'(1)) : '0;
  assign step   = tick & running & (pre == lim);
  assign reload = trig_fire & (trig_val != last_trig);
  assign ovf    = step & (&cnt) & ~reload;
  assign rst_o  = (rstc != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      pre       <= '0;
      last_trig <= '0;
      rstc      <= '0;
    end else begin
      if (trig_fire) last_trig <= trig_val;
      if (!running)  pre <= '0;
      else if (tick) pre <= (pre == lim) ? '0 : pre + PRE_W'(1);
      if (reload)    cnt <= load_val;
      else if (step) cnt <= (&cnt) ? load_val : cnt + CNT_W'(1);
      if (ovf)                rstc <= RW'(RST_CYCLES);
      else if (rstc != '0)    rstc <= rstc - RW'(1);
    end
  end

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  // R10
  rst_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |-> (cnt == $past(load_val)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int         ADDR_W     = 3,
  parameter int         DATA_W     = 32,
  parameter int         CNT_W      = 32,
  parameter int         PEND_TICKS = 3,
  parameter int         RST_CYCLES = 4,
  parameter logic [7:0] REV        = 8'h3A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wdt_rst_o
);
  import wdt_pkg::*;
  localparam int CTRL_W = 6;

  logic              wr_ctrl, wr_load, wr_trig, wr_key;
  logic              p_ctrl, p_load, p_trig, p_key;
  logic              f_ctrl, f_load, f_trig, f_key;
  logic [CTRL_W-1:0] q_ctrl, ctrl_q;
  logic [CNT_W-1:0]  q_load, load_q, cnt;
  logic [DATA_W-1:0] q_trig, q_key, last_trig;
  logic              running;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
  assign wr_load = wr_en && (addr == ADDR_W'(A_LOAD));
  assign wr_trig = wr_en && (addr == ADDR_W'(A_TRIG));
  assign wr_key  = wr_en && (addr == ADDR_W'(A_KEY));

  wdt_post #(.DW(CTRL_W), .LAT(PEND_TICKS)) u_post_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr_ctrl), .din(wdata[CTRL_W-1:0]),
    .q(q_ctrl), .pend(p_ctrl), .fire(f_ctrl));
  wdt_post #(.DW(CNT_W), .LAT(PEND_TICKS)) u_post_load (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr_load), .din(wdata[CNT_W-1:0]),
    .q(q_load), .pend(p_load), .fire(f_load));
  wdt_post #(.DW(DATA_W), .LAT(PEND_TICKS)) u_post_trig (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr_trig), .din(wdata),
    .q(q_trig), .pend(p_trig), .fire(f_trig));
  wdt_post #(.DW(DATA_W), .LAT(PEND_TICKS)) u_post_key (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr_key), .din(wdata),
    .q(q_key), .pend(p_key), .fire(f_key));

  wdt_keyseq #(.DW(DATA_W)) u_keys (
    .clk(clk), .rst(rst), .fire(f_key), .word(q_key), .running(running));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else if (!running) begin
      if (f_ctrl) ctrl_q <= q_ctrl;
      if (f_load) load_q <= q_load;
    end
  end

  wdt_core #(.CNT_W(CNT_W), .DW(DATA_W), .RST_CYCLES(RST_CYCLES)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .running(running),
    .pre_en(ctrl_q[5]), .pre_exp(ctrl_q[4:2]), .load_val(load_q),
    .trig_fire(f_trig), .trig_val(q_trig), .cnt(cnt), .last_trig(last_trig),
    .rst_o(wdt_rst_o));

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        ADDR_W'(A_REV):   rdata <= DATA_W'(REV);
        ADDR_W'(A_CTRL):  rdata <= DATA_W'(ctrl_q);
        ADDR_W'(A_LOAD):  rdata <= DATA_W'(load_q);
        ADDR_W'(A_TRIG):  rdata <= last_trig;
        ADDR_W'(A_KEY):   rdata <= DATA_W'(running);
        ADDR_W'(A_STAT):  rdata <= DATA_W'({p_key, p_trig, p_load, 1'b0, p_ctrl});
        ADDR_W'(A_COUNT): rdata <= DATA_W'(cnt);
        default:          rdata <= '0;
      endcase
    end
  end

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    running |=> ($stable(ctrl_q) && $stable(load_q)));
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = 3'd6;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst_o;

  always #2 clk = ~clk;

  wdog_timer u_wdog_timer (.clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wdt_rst_o(wdt_rst_o));

  localparam int PT = 3, RC = 4;
  int nvec = 0, nbad = 0, cyc = 0, rst_hi = 0;
  string phase = "R1";

  logic [5:0]  m_ctrl;
  logic [31:0] m_load, m_last, m_cnt, m_rd;
  logic [31:0] m_pd[4];
  bit          m_run, m_pend[4];
  int          m_ks, m_pc[4], m_pre, m_rstc;

  task automatic model_update();
    bit f[4]; int div; bit stp, rl, ov;
    logic [31:0] ncnt;
    if (rst) begin
      m_ctrl = 0; m_load = 0; m_last = 0; m_cnt = 0; m_rd = 0; m_run = 0;
      m_ks = 0; m_pre = 0; m_rstc = 0;
      for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_pc[i] = 0; m_pd[i] = 0; end
      return;
    end
    case (addr)
      3'd0: m_rd = 32'h3A;
      3'd1: m_rd = {26'd0, m_ctrl};
      3'd2: m_rd = m_load;
      3'd3: m_rd = m_last;
      3'd4: m_rd = {31'd0, m_run};
      3'd5: m_rd = {27'd0, m_pend[3], m_pend[2], m_pend[1], 1'b0, m_pend[0]};
      3'd6: m_rd = m_cnt;
      default: m_rd = 0;
    endcase
    for (int i = 0; i < 4; i++)
      f[i] = tick && m_pend[i] && m_pc[i] == 1 && !(wr_en && addr == 3'(i + 1));
    div = m_ctrl[5] ? (1 << m_ctrl[4:2]) : 1;
    stp = tick && m_run && (m_pre == div - 1);
    rl  = f[2] && (m_pd[2] != m_last);
    ov  = 0;
    ncnt = m_cnt;
    if (rl) ncnt = m_load;
    else if (stp) begin
      if (m_cnt == 32'hFFFF_FFFF) begin ncnt = m_load; ov = 1; end
      else ncnt = m_cnt + 1;
    end
    if (!m_run) m_pre = 0;
    else if (tick) m_pre = (m_pre == div - 1) ? 0 : m_pre + 1;
    if (ov) m_rstc = RC; else if (m_rstc > 0) m_rstc--;
    m_cnt = ncnt;
    if (f[2]) m_last = m_pd[2];
    if (!m_run) begin
      if (f[0]) m_ctrl = m_pd[0][5:0];
      if (f[1]) m_load = m_pd[1];
    end
    if (f[3]) begin
      case (m_ks)
        1: begin if (m_pd[3] == 32'h4444) m_run = 1; m_ks = 0; end
        2: begin if (m_pd[3] == 32'h5555) m_run = 0; m_ks = 0; end
        default: m_ks = (m_pd[3] == 32'hBBBB) ? 1 : (m_pd[3] == 32'hAAAA) ? 2 : 0;
      endcase
    end
    for (int i = 0; i < 4; i++) begin
      if (wr_en && addr == 3'(i + 1)) begin m_pend[i] = 1; m_pc[i] = PT; m_pd[i] = wdata; end
      else if (f[i]) m_pend[i] = 0;
      else if (tick && m_pend[i]) m_pc[i]--;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(bit w, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tick = (cyc % 3 == 2);
    @(posedge clk);
    model_update();
    cyc++;
    #1;
    check({phase, " rdata"}, rdata, m_rd);
    check({phase, " rst_o"}, {31'd0, wdt_rst_o}, {31'd0, m_rstc != 0});
    if (wdt_rst_o) rst_hi++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 3'd6, 0);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    step(1, a, d);
    idle(3 * PT + 3);
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
    step(0, a, 0);
    check(tag, rdata, exp);
  endtask

  initial begin
    #(4 * 200000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    phase = "R1";
    rd("R1 counter", 3'd6, 0); rd("R1 reload", 3'd2, 0);
    rd("R1 status", 3'd5, 0);  rd("R1 armed", 3'd4, 0);
    rd("R1 refresh", 3'd3, 0);
    phase = "R2";
    rd("R2 revision", 3'd0, 32'h3A); rd("R2 unmapped", 3'd7, 0);
    phase = "R3";
    step(1, 3'd2, 32'h100);
    rd("R3 load pending bit2", 3'd5, 32'h4);
    idle(3 * PT + 3);
    rd("R3 pending cleared", 3'd5, 0); rd("R3 reload applied", 3'd2, 32'h100);
    step(1, 3'd4, 32'h1);
    rd("R3 key pending bit4", 3'd5, 32'h10);
    idle(3 * PT + 3);
    phase = "R9";
    wr(3'd3, 32'h0); rd("R9 same word no reload", 3'd6, 0);
    wr(3'd3, 32'h5); rd("R9 new word reloads", 3'd6, 32'h100);
    phase = "R4";
    wr(3'd4, 32'hBBBB); wr(3'd4, 32'h4444);
    rd("R4 armed", 3'd4, 1);
    idle(30);
    phase = "R9";
    wr(3'd3, 32'h5); idle(10);
    phase = "R7";
    wr(3'd1, 32'h2C); wr(3'd2, 32'h55);
    rd("R7 ctrl frozen", 3'd1, 0); rd("R7 reload frozen", 3'd2, 32'h100);
    phase = "R6";
    wr(3'd4, 32'hAAAA); wr(3'd4, 32'h1234); wr(3'd4, 32'h5555);
    rd("R6 cancelled pair still armed", 3'd4, 1);
    phase = "R5";
    wr(3'd4, 32'hAAAA); wr(3'd4, 32'h5555);
    rd("R5 disarmed", 3'd4, 0);
    idle(20);
    phase = "R6";
    wr(3'd4, 32'h4444); rd("R6 lone second word", 3'd4, 0);
    wr(3'd4, 32'hBBBB); wr(3'd4, 32'hAAAA); wr(3'd4, 32'h4444);
    rd("R6 broken arm pair", 3'd4, 0);
    phase = "R8";
    wr(3'd1, 32'h28); rd("R8 ctrl applied", 3'd1, 32'h28);
    wr(3'd3, 32'hA);
    wr(3'd4, 32'hBBBB); wr(3'd4, 32'h4444);
    idle(150);
    wr(3'd4, 32'hAAAA); wr(3'd4, 32'h5555);
    phase = "R10";
    wr(3'd1, 32'h0); wr(3'd2, 32'hFFFF_FFF0); wr(3'd3, 32'h1234);
    rd("R10 preload", 3'd6, 32'hFFFF_FFF0);
    wr(3'd4, 32'hBBBB); step(1, 3'd4, 32'h4444);
    rst_hi = 0;
    idle(70);
    check("R10 pulse width", rst_hi, RC);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule